// File: doc/BRIEF.md
# Power-Good and Wake Policy Controller

This block watches the platform's power-good sources and the standby-rail reset. It decides whether the platform should be asked to boot when core power comes back. All power-good sources are combined into one internal power-good, which is their AND. A drop of that signal while the standby rail stays valid is a core-only event. It sets a sticky failure flag and always leads to a boot request when power returns. If the standby reset asserts before power-good recovers, the event is a full power loss. In that case a stay-off policy bit decides between booting and remaining in soft-off.

The block also qualifies wake requests against a battery-low level. It pulses a system-management interrupt when the battery goes low while the platform is working. It raises a pad-isolation enable in the deep sleep states, so that pads facing unpowered planes are floated or held low. All inputs are synchronous, debounced levels. Every output is registered and changes one clock after the input that causes it.

Top module: `pwr_wake_ctrl`

## Requirements
- R1: Internal power-good is the AND of all `pg_src_i` bits; no boot request is issued while any bit is low.
- R2: When power-good falls in the running state while `stby_rst_ni` is high, `core_fail_o` is set on the next clock.
- R3: `core_fail_o` clears one clock after `flag_clr_i` is high or `stby_rst_ni` is low. When a set and a clear strobe coincide, the set wins.
- R4: After a core-only drop, the return of power-good gives a boot request one clock later, whatever the value of `stay_off_i`.
- R5: After a full power loss (`stby_rst_ni` low while power-good is low, and also after `rst_ni`), the return of power-good boots only when `stay_off_i` is 0. With 1, the block settles in soft-off and issues no request.
- R6: `boot_req_o` is a single-cycle pulse. No request is issued while `stby_rst_ni` is low; one is issued on the clock after it goes high, if power-good is high by then.
- R7: `wake_ok_o` is high one clock after `wake_req_i` is high, `batlow_i` is low and `slp_state_i` is not 0 (working).
- R8: `smi_o` pulses for one clock after a rising edge of `batlow_i` while `slp_state_i` is 0. It gives no repeat while the level stays high, and no pulse in a sleep state.
- R9: `pad_iso_o` is high one clock after `slp_state_i` is 3 (suspend-to-RAM) or 5 (soft-off). It is low for 0 (working) and 2 (light processor stop).
- R10: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_src_i | input | N_PG | Power-good sources (supply, processor regulator) |
| stby_rst_ni | input | 1 | Standby-rail reset, active low, synchronous level |
| stay_off_i | input | 1 | After-loss policy: 0 boot, 1 stay in soft-off |
| flag_clr_i | input | 1 | Write-one-to-clear strobe for the failure flag |
| batlow_i | input | 1 | Battery low level |
| slp_state_i | input | SLP_W | Sleep-state code |
| wake_req_i | input | 1 | Wake request |
| boot_req_o | output | 1 | Boot request pulse |
| core_fail_o | output | 1 | Sticky core-power-failure flag |
| smi_o | output | 1 | System-management interrupt pulse |
| wake_ok_o | output | 1 | Qualified wake |
| pad_iso_o | output | 1 | Pad isolation enable |

## Verification
The bench builds the block with its defaults: two power-good sources, a 3-bit sleep code, working code 0 and an isolation mask selecting codes 3 and 5. Two sources allow one source alone to be high, which shows that power-good is a true AND and not an OR. The 3-bit code reaches the working, light-stop, suspend and soft-off codes, so the wake qualification and the pad mask are both tested in sleep codes that isolate and in codes that do not.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
  typedef enum logic [1:0] {
    PS_FAIL = 2'd0,  // full loss seen, waiting for power
    PS_ON   = 2'd1,
    PS_DROP = 2'd2,  // core-only drop
    PS_OFF  = 2'd3   // soft-off by policy
  } pwr_st_e;
endpackage

// File: rtl/pwc_power_fsm.sv
module pwc_power_fsm
  import pwc_pkg::*;
#(
  parameter int N_PG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PG-1:0] pg_src_i,
  input  logic            stby_rst_ni,
  input  logic            stay_off_i,
  input  logic            flag_clr_i,
  output logic            boot_req_o,
  output logic            core_fail_o
);
  pwr_st_e st_q, st_d;
  logic    pg, boot_d, flag_set, flag_d;

  assign pg = &pg_src_i;

  always_comb begin
    st_d   = st_q;
    boot_d = 1'b0;
    unique case (st_q)
      PS_ON:   if (!pg) st_d = stby_rst_ni ? PS_DROP : PS_FAIL;
      PS_DROP: begin
        if (!stby_rst_ni) st_d = PS_FAIL;
        else if (pg) begin
          st_d   = PS_ON;
          boot_d = 1'b1;
        end
      end
      PS_FAIL: begin
        if (pg && stby_rst_ni) begin
          st_d   = stay_off_i ? PS_OFF : PS_ON;
          boot_d = !stay_off_i;
        end
      end
      PS_OFF:  if (!pg && !stby_rst_ni) st_d = PS_FAIL;
      default: st_d = PS_FAIL;
    endcase
  end

  assign flag_set = (st_q == PS_ON) && !pg && stby_rst_ni;
  assign flag_d   = flag_set || (core_fail_o && !flag_clr_i && stby_rst_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= PS_FAIL;
      boot_req_o  <= 1'b0;
      core_fail_o <= 1'b0;
    end else begin
      st_q        <= st_d;
      boot_req_o  <= boot_d;
      core_fail_o <= flag_d;
    end
  end

  assert_boot_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_req_o |=> !boot_req_o);
  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_ON && !pg && stby_rst_ni) |=> core_fail_o);
  assert_flag_stby_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stby_rst_ni |=> !core_fail_o);
  assert_stay_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_FAIL && stay_off_i) |=> !boot_req_o);
  assert_no_boot_low_pg_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pg |=> !boot_req_o);
endmodule

// File: rtl/pwc_batt.sv
module pwc_batt #(
  parameter int              SLP_W     = 3,
  parameter logic [SLP_W-1:0] WORK_CODE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             batlow_i,
  input  logic [SLP_W-1:0] slp_state_i,
  input  logic             wake_req_i,
  output logic             smi_o,
  output logic             wake_ok_o
);
  logic batlow_q, working;

  assign working = (slp_state_i == WORK_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      batlow_q  <= 1'b0;
      smi_o     <= 1'b0;
      wake_ok_o <= 1'b0;
    end else begin
      batlow_q  <= batlow_i;
      smi_o     <= batlow_i && !batlow_q && working;
      wake_ok_o <= wake_req_i && !batlow_i && !working;
    end
  end

  assert_smi_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |=> !smi_o);
  assert_wake_batlow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_ok_o |-> $past(!batlow_i));
endmodule

// File: rtl/pwc_pad.sv
module pwc_pad #(
  parameter int                  SLP_W    = 3,
  parameter int                  N_CODES  = 1 << SLP_W,
  parameter logic [N_CODES-1:0]  ISO_MASK = N_CODES'(8'h28)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SLP_W-1:0] slp_state_i,
  output logic             pad_iso_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pad_iso_o <= 1'b0;
    else         pad_iso_o <= ISO_MASK[slp_state_i];
  end
endmodule

// File: rtl/pwr_wake_ctrl.sv
module pwr_wake_ctrl #(
  parameter int               N_PG      = 2,
  parameter int               SLP_W     = 3,
  parameter logic [SLP_W-1:0] WORK_CODE = '0,
  localparam int              N_CODES   = 1 << SLP_W,
  parameter logic [N_CODES-1:0] ISO_MASK = N_CODES'(8'h28)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_PG-1:0]  pg_src_i,
  input  logic             stby_rst_ni,
  input  logic             stay_off_i,
  input  logic             flag_clr_i,
  input  logic             batlow_i,
  input  logic [SLP_W-1:0] slp_state_i,
  input  logic             wake_req_i,
  output logic             boot_req_o,
  output logic             core_fail_o,
  output logic             smi_o,
  output logic             wake_ok_o,
  output logic             pad_iso_o
);
  pwc_power_fsm #(.N_PG(N_PG)) u_pwr (
    .clk_i, .rst_ni, .pg_src_i, .stby_rst_ni, .stay_off_i, .flag_clr_i,
    .boot_req_o, .core_fail_o
  );

  pwc_batt #(.SLP_W(SLP_W), .WORK_CODE(WORK_CODE)) u_batt (
    .clk_i, .rst_ni, .batlow_i, .slp_state_i, .wake_req_i, .smi_o, .wake_ok_o
  );

  pwc_pad #(.SLP_W(SLP_W), .N_CODES(N_CODES), .ISO_MASK(ISO_MASK)) u_pad (
    .clk_i, .rst_ni, .slp_state_i, .pad_iso_o
  );

  assert_reset_quiet_R10: assert property (@(posedge clk_i)
    !rst_ni |-> !(boot_req_o || core_fail_o || smi_o || wake_ok_o || pad_iso_o));
endmodule

// File: tb/pwr_wake_ctrl_tb.sv
module pwr_wake_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] pg_src = 2'b00;
  logic       stby_rst_n = 1'b0, stay_off = 1'b0, flag_clr = 1'b0;
  logic       batlow = 1'b0, wake_req = 1'b0;
  logic [2:0] slp = 3'd0;
  logic       boot, cfail, smi, wake_ok, iso;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  pwr_wake_ctrl u_dut (
    .clk_i(clk), .rst_ni, .pg_src_i(pg_src), .stby_rst_ni(stby_rst_n),
    .stay_off_i(stay_off), .flag_clr_i(flag_clr), .batlow_i(batlow),
    .slp_state_i(slp), .wake_req_i(wake_req), .boot_req_o(boot),
    .core_fail_o(cfail), .smi_o(smi), .wake_ok_o(wake_ok), .pad_iso_o(iso)
  );

  typedef struct packed {
    logic [2:0] slp;
    logic       bl;
    logic       wk;
    logic       exp_wake;
    logic       exp_iso;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{3'd0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{3'd2, 1'b0, 1'b1, 1'b1, 1'b0},
    '{3'd2, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'd3, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd3, 1'b1, 1'b1, 1'b0, 1'b1},
    '{3'd5, 1'b0, 1'b1, 1'b1, 1'b1},
    '{3'd5, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'd2, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R10 reset state, inputs active to provoke outputs
    pg_src = 2'b11; slp = 3'd3; wake_req = 1'b1; batlow = 1'b0;
    repeat (3) tick();
    check("R10 boot", boot, 1'b0);
    check("R10 flag", cfail, 1'b0);
    check("R10 iso", iso, 1'b0);
    check("R10 wake", wake_ok, 1'b0);
    pg_src = 2'b00; slp = 3'd0; wake_req = 1'b0;
    stby_rst_n = 1'b1;
    tick();
    rst_ni = 1'b1;
    tick();

    // R1 one source alone is not power-good
    pg_src = 2'b01; tick();
    check("R1 partial pg", boot, 1'b0);
    pg_src = 2'b10; tick();
    check("R1 partial pg", boot, 1'b0);
    // R5 reset counts as full loss, policy 0 boots
    pg_src = 2'b11; tick();
    check("R5 boot after reset", boot, 1'b1);
    tick();
    check("R6 single pulse", boot, 1'b0);

    // R2 core-only drop, R4 boot despite stay_off
    pg_src = 2'b10; tick();
    check("R2 flag set", cfail, 1'b1);
    stay_off = 1'b1; pg_src = 2'b11; tick();
    check("R4 boot ignores policy", boot, 1'b1);
    tick();
    check("R6 single pulse", boot, 1'b0);
    check("R3 flag sticky", cfail, 1'b1);
    flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    check("R3 w1c clear", cfail, 1'b0);

    // R5 full loss with stay_off=1
    pg_src = 2'b00; tick();
    check("R2 flag set again", cfail, 1'b1);
    stby_rst_n = 1'b0; tick();
    check("R3 standby reset clears", cfail, 1'b0);
    stby_rst_n = 1'b1; tick();
    pg_src = 2'b11; tick();
    check("R5 stay off", boot, 1'b0);
    tick();
    check("R5 stay off hold", boot, 1'b0);

    // R5 full loss with policy 0; R6 held off by standby reset
    pg_src = 2'b00; stby_rst_n = 1'b0; tick();
    stay_off = 1'b0; pg_src = 2'b11; tick();
    check("R6 no boot in standby reset", boot, 1'b0);
    stby_rst_n = 1'b1; tick();
    check("R5 boot policy 0", boot, 1'b1);
    tick();
    check("R6 single pulse", boot, 1'b0);

    // R3 set beats clear
    pg_src = 2'b01; flag_clr = 1'b1; tick(); flag_clr = 1'b0;
    check("R3 set wins", cfail, 1'b1);
    pg_src = 2'b11; tick();
    check("R4 boot after drop", boot, 1'b1);

    // R8 SMI
    slp = 3'd0; batlow = 1'b0; tick();
    batlow = 1'b1; tick();
    check("R8 smi on rise", smi, 1'b1);
    tick();
    check("R8 no repeat", smi, 1'b0);
    batlow = 1'b0; slp = 3'd3; tick();
    batlow = 1'b1; tick();
    check("R8 none while asleep", smi, 1'b0);
    batlow = 1'b0; tick();

    // R7 / R9 vector walk
    foreach (VEC[i]) begin
      slp = VEC[i].slp; batlow = VEC[i].bl; wake_req = VEC[i].wk;
      tick();
      check("R7 wake gate", wake_ok, VEC[i].exp_wake);
      check("R9 pad iso", iso, VEC[i].exp_iso);
    end

    finish_run();
  end
endmodule